// File: doc/BRIEF.md
# Three-Plane Window Compositor

The compositor turns up to three pixel channels into one output pixel per clock. Each channel has a rectangular window, set by a top-left corner word and a bottom-right corner word. The channel's pixel is shown only while the raster position given by the x/y counters lies inside that window. Channel 1 sits on top and is blended over whatever lies beneath it. Its alpha comes either from a global default held in the control word or from the alpha value that arrives with its pixel. Channels 2 and 3 are opaque. Where no window covers the position, a background colour is shown.

The control word, the window corners, the background colours and the channel pixels all come from registers and a fetch path outside the block. The block only decides coverage and priority and does the blend. The result appears two clocks after the position that produced it, together with a valid flag that follows the same delay.

Top module: `plane_compositor`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `out_vld` is 0 and `out_pix` is all zero.
- R2: `out_vld` equals `pos_vld` from two clocks earlier. The pixel presented with a position shows up on `out_pix` after the same two clocks. Whenever `out_vld` is 0, `out_pix` is all zero.
- R3: A window covers position (x, y) when x lies within its two corner x fields and y lies within its two corner y fields, with all four bounds inclusive. In each corner word, x is in bits 12:0 and y is in bits 28:16.
- R4: The enable for channel 1 is control bit 2, the enable for channel 2 is bit 1, and the enable for channel 3 is bit 0. A channel whose bit is clear never appears on the output.
- R5: A window whose top-left and bottom-right words are both zero covers nothing, including position (0, 0).
- R6: Channel 2 covers channel 3. Channel 1 is blended over whatever channel 2, channel 3 or the background leaves below it.
- R7: When control bit 10 is 0, channel 1 uses the 8-bit alpha in control bits 31:24, and the `ch1_alpha` input has no effect. Each component is computed as (a*fg + (255-a)*bg + 127) / 255, using integer division.
- R8: When control bit 10 is 1, channel 1 uses the `ch1_alpha` input, and control bits 31:24 have no effect.
- R9: Where no enabled window covers the position, the output is the background colour of the lowest-numbered enabled channel. When no channel is enabled, the output is zero.
- R10: In every colour word, the three 10-bit components sit at bits 29:20, 19:10 and 9:0. An alpha of 255 returns the channel 1 component exactly, and an alpha of 0 returns the lower layer exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pos_x | input | 13 | Horizontal raster counter |
| pos_y | input | 13 | Vertical raster counter |
| pos_vld | input | 1 | Position is a real pixel |
| ctrl | input | 32 | Enables (bits 2:0), alpha source select (bit 10), default alpha (bits 31:24) |
| win_tl | input | 3x32 | Top-left corner per channel, index 0 = channel 1 |
| win_br | input | 3x32 | Bottom-right corner per channel |
| bg_color | input | 3x32 | Background colour per channel |
| ch_pix | input | 3x32 | Pixel colour per channel |
| ch1_alpha | input | 8 | Per-pixel alpha for channel 1 |
| out_pix | output | 30 | Composited pixel |
| out_vld | output | 1 | Output pixel valid |

## Verification
A raster sweep runs over three overlapping windows with distinct colours, one just past each window edge. It separates inclusive bounds from exclusive ones and a correct priority order from a reversed one. The channel enables are then turned off one at a time, and windows are reduced to all-zero corners, to show which background colour wins and that an empty window at the origin stays hidden. Alpha sweeps cover 0, 255 and values in between under both alpha sources. Throughout the sweeps, the unselected alpha source is varied, so a wrong source select or a rounding error in the divide shows up as a wrong component.

// File: rtl/comp_pkg.sv
package comp_pkg;
    localparam int REG_W         = 32;
    localparam int COORD_W       = 13;
    localparam int X_LSB         = 0;
    localparam int Y_LSB         = 16;
    localparam int COMP_W        = 10;
    localparam int NCOMP         = 3;
    localparam int COLOR_W       = COMP_W * NCOMP;
    localparam int ALPHA_W       = 8;
    localparam int ALPHA_SEL_BIT = 10;
    localparam int DEF_ALPHA_LSB = 24;

    // element [NCOMP-1] is the most significant component of a colour word
    typedef logic [NCOMP-1:0][COMP_W-1:0] rgb_t;

    typedef struct packed {
        logic               vld;
        logic [ALPHA_W-1:0] a;
        rgb_t               fg;
        rgb_t               lo;
    } stage1_t;

    typedef struct packed {
        logic vld;
        rgb_t pix;
    } stage2_t;

    function automatic logic [COORD_W-1:0] corner_x(input logic [REG_W-1:0] r);
        return r[X_LSB +: COORD_W];
    endfunction

    function automatic logic [COORD_W-1:0] corner_y(input logic [REG_W-1:0] r);
        return r[Y_LSB +: COORD_W];
    endfunction
endpackage

// File: rtl/comp_window_hit.sv
module comp_window_hit
    import comp_pkg::*;
(
    input  logic               en,
    input  logic [REG_W-1:0]   tl,
    input  logic [REG_W-1:0]   br,
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    output logic               hit
);
    logic empty;
    logic in_x;
    logic in_y;
    logic unused_corner_bits;

    assign empty = (tl == '0) && (br == '0);
    assign in_x  = (x >= corner_x(tl)) && (x <= corner_x(br));
    assign in_y  = (y >= corner_y(tl)) && (y <= corner_y(br));
    assign hit   = en && !empty && in_x && in_y;

    assign unused_corner_bits = ^{tl, br};
endmodule

// File: rtl/comp_blend_lane.sv
module comp_blend_lane
    import comp_pkg::*;
(
    input  logic [ALPHA_W-1:0] a,
    input  logic [COMP_W-1:0]  fg,
    input  logic [COMP_W-1:0]  bg,
    output logic [COMP_W-1:0]  res
);
    localparam int SW   = COMP_W + ALPHA_W + 1;
    localparam int AMAX = (1 << ALPHA_W) - 1;

    logic [SW-1:0] a_w;
    logic [SW-1:0] ia_w;
    logic [SW-1:0] sum;
    logic [SW-1:0] quo;
    logic          unused_quo_bits;

    always_comb begin
        a_w  = SW'(a);
        ia_w = SW'(AMAX) - a_w;
        sum  = a_w * SW'(fg) + ia_w * SW'(bg) + SW'(AMAX / 2);
        quo  = sum / SW'(AMAX);
        res  = quo[COMP_W-1:0];
    end

    assign unused_quo_bits = ^quo;
endmodule

// File: rtl/plane_compositor.sv
module plane_compositor
    import comp_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [COORD_W-1:0]        pos_x,
    input  logic [COORD_W-1:0]        pos_y,
    input  logic                      pos_vld,
    input  logic [REG_W-1:0]          ctrl,
    input  logic [NCH-1:0][REG_W-1:0] win_tl,
    input  logic [NCH-1:0][REG_W-1:0] win_br,
    input  logic [NCH-1:0][REG_W-1:0] bg_color,
    input  logic [NCH-1:0][REG_W-1:0] ch_pix,
    input  logic [ALPHA_W-1:0]        ch1_alpha,
    output logic [COLOR_W-1:0]        out_pix,
    output logic                      out_vld
);
    logic [NCH-1:0] ch_en;
    logic [NCH-1:0] ch_hit;
    stage1_t        s1_d, s1_q;
    stage2_t        s2_d, s2_q;
    rgb_t           blend;
    logic           unused_in_bits;

    // channel index 0 is the top plane; its enable is the highest of the enable bits
    for (genvar g = 0; g < NCH; g++) begin : g_win
        assign ch_en[g] = ctrl[NCH-1-g];
        comp_window_hit u_hit (
            .en  (ch_en[g]),
            .tl  (win_tl[g]),
            .br  (win_br[g]),
            .x   (pos_x),
            .y   (pos_y),
            .hit (ch_hit[g])
        );
    end

    // stage 1: coverage, priority and alpha source
    always_comb begin
        rgb_t lower;
        s1_d     = '0;
        lower    = '0;
        s1_d.vld = pos_vld;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (ch_en[i]) lower = bg_color[i][COLOR_W-1:0];
        end
        for (int i = NCH - 1; i >= 1; i--) begin
            if (ch_hit[i]) lower = ch_pix[i][COLOR_W-1:0];
        end
        if (pos_vld) begin
            s1_d.lo = lower;
            s1_d.fg = ch_pix[0][COLOR_W-1:0];
            if (ch_hit[0]) begin
                s1_d.a = ctrl[ALPHA_SEL_BIT] ? ch1_alpha : ctrl[DEF_ALPHA_LSB +: ALPHA_W];
            end
        end
    end

    // stage 2: per-component blend; alpha 0 passes the lower layer unchanged
    for (genvar c = 0; c < NCOMP; c++) begin : g_lane
        comp_blend_lane u_lane (
            .a   (s1_q.a),
            .fg  (s1_q.fg[c]),
            .bg  (s1_q.lo[c]),
            .res (blend[c])
        );
    end

    always_comb begin
        s2_d.vld = s1_q.vld;
        s2_d.pix = s1_q.vld ? blend : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_pix = s2_q.pix;
    assign out_vld = s2_q.vld;

    assign unused_in_bits = ^{ctrl, bg_color, ch_pix};
endmodule

// File: rtl/comp_checker.sv
module comp_checker
    import comp_pkg::*;
#(
    parameter int NCH = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      pos_vld,
    input logic [REG_W-1:0]          ctrl,
    input logic [NCH-1:0][REG_W-1:0] win_tl,
    input logic [NCH-1:0][REG_W-1:0] win_br,
    input logic [NCH-1:0][REG_W-1:0] bg_color,
    input logic [COLOR_W-1:0]        out_pix,
    input logic                      out_vld
);
    logic [1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cyc <= '0;
        else if (cyc != 2'd2) cyc <= cyc + 2'd1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd0) |-> (!out_vld && out_pix == '0)); // R1

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd2) |-> (out_vld == $past(pos_vld, 2))); // R2

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (out_pix == '0)); // R2

    AST_NONE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd2 && $past(ctrl[NCH-1:0], 2) == '0) |-> (out_pix == '0)); // R9

    AST_EMPTY_WINDOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd2 && $past(pos_vld, 2) && $past(win_tl, 2) == '0 &&
         $past(win_br, 2) == '0 && $past(ctrl[NCH-1], 2))
        |-> (out_pix == $past(bg_color[0][COLOR_W-1:0], 2))); // R5
endmodule

bind plane_compositor comp_checker #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pos_vld  (pos_vld),
    .ctrl     (ctrl),
    .win_tl   (win_tl),
    .win_br   (win_br),
    .bg_color (bg_color),
    .out_pix  (out_pix),
    .out_vld  (out_vld)
);

// File: tb/plane_compositor_tb.sv
module plane_compositor_tb_top;
    import comp_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 3;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [COORD_W-1:0]        pos_x = '0;
    logic [COORD_W-1:0]        pos_y = '0;
    logic                      pos_vld = 1'b0;
    logic [REG_W-1:0]          ctrl = '0;
    logic [NCH-1:0][REG_W-1:0] win_tl = '0;
    logic [NCH-1:0][REG_W-1:0] win_br = '0;
    logic [NCH-1:0][REG_W-1:0] bg_color = '0;
    logic [NCH-1:0][REG_W-1:0] ch_pix = '0;
    logic [ALPHA_W-1:0]        ch1_alpha = '0;
    logic [COLOR_W-1:0]        out_pix;
    logic                      out_vld;

    typedef struct {
        logic               v;
        logic [COLOR_W-1:0] p;
        string              tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    plane_compositor #(.NCH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .pos_x(pos_x), .pos_y(pos_y), .pos_vld(pos_vld),
        .ctrl(ctrl), .win_tl(win_tl), .win_br(win_br), .bg_color(bg_color),
        .ch_pix(ch_pix), .ch1_alpha(ch1_alpha), .out_pix(out_pix), .out_vld(out_vld)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [REG_W-1:0] corner(input int x, input int y);
        logic [REG_W-1:0] r = '0;
        r[12:0]  = 13'(x);
        r[28:16] = 13'(y);
        return r;
    endfunction

    function automatic logic [REG_W-1:0] colour(input int r, input int g, input int b);
        return {2'b00, 10'(r), 10'(g), 10'(b)};
    endfunction

    // reference model written from the requirements
    function automatic logic [COLOR_W-1:0] model(input int x, input int y);
        bit hit [NCH];
        bit en  [NCH];
        logic [COLOR_W-1:0] lo = '0;
        logic [COLOR_W-1:0] res;
        bit found = 0;
        int a;
        en[0] = ctrl[2]; en[1] = ctrl[1]; en[2] = ctrl[0];
        for (int i = 0; i < NCH; i++) begin
            hit[i] = en[i] && !(win_tl[i] == 0 && win_br[i] == 0) &&
                     x >= int'(win_tl[i][12:0])  && x <= int'(win_br[i][12:0]) &&
                     y >= int'(win_tl[i][28:16]) && y <= int'(win_br[i][28:16]);
        end
        for (int i = 1; i < NCH; i++) begin
            if (!found && hit[i]) begin lo = ch_pix[i][29:0]; found = 1; end
        end
        for (int i = 0; i < NCH; i++) begin
            if (!found && en[i]) begin lo = bg_color[i][29:0]; found = 1; end
        end
        if (!hit[0]) return lo;
        a = ctrl[10] ? int'(ch1_alpha) : int'(ctrl[31:24]);
        for (int c = 0; c < 3; c++) begin
            int f = int'(ch_pix[0][c*10 +: 10]);
            int b = int'(lo[c*10 +: 10]);
            res[c*10 +: 10] = 10'((a * f + (255 - a) * b + 127) / 255);
        end
        return res;
    endfunction

    task automatic drive(input int x, input int y, input bit v, input string tag);
        exp_t e;
        @(negedge clk);
        pos_x   = 13'(x);
        pos_y   = 13'(y);
        pos_vld = v;
        e.v     = v;
        e.p     = v ? model(x, y) : '0;
        e.tag   = tag;
        q.push_back(e);
        @(posedge clk);
        #1;
    endtask

    // monitor: the item pushed two edges ago is due now
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #1;
            if (q.size() >= 2) begin
                e = q.pop_front();
                n_cmp++;
                if (out_vld !== e.v || out_pix !== e.p) begin
                    n_bad++;
                    $display("FAIL %s: got vld=%0b pix=%h, expected vld=%0b pix=%h",
                             e.tag, out_vld, out_pix, e.v, e.p);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        ctrl = {8'd255, 13'd0, 1'b0, 7'd0, 3'b111};
        win_tl[0] = corner(10, 5);  win_br[0] = corner(20, 8);
        win_tl[1] = corner(15, 6);  win_br[1] = corner(30, 12);
        win_tl[2] = corner(2, 2);   win_br[2] = corner(40, 20);
        ch_pix[0] = colour(1000, 600, 40);
        ch_pix[1] = colour(100, 900, 333);
        ch_pix[2] = colour(512, 7, 1023);
        bg_color[0] = colour(11, 22, 33);
        bg_color[1] = colour(444, 555, 666);
        bg_color[2] = colour(777, 888, 999);
        ch1_alpha = 8'd3;

        repeat (3) @(posedge clk);
        #1;
        n_cmp++;
        if (out_vld !== 1'b0 || out_pix !== '0) begin
            n_bad++;
            $display("FAIL R1: got vld=%0b pix=%h, expected vld=0 pix=0", out_vld, out_pix);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2: idle positions give zero output
        drive(12, 6, 0, "R2");
        drive(12, 6, 1, "R2");
        drive(12, 6, 0, "R2");

        // R3 / R6: sweep across the overlapping windows and their edges
        for (int y = 1; y <= 13; y++)
            for (int x = 8; x <= 32; x += 2)
                drive(x, y, 1, "R3");
        drive(9, 5, 1, "R3");   drive(10, 4, 1, "R3");
        drive(21, 8, 1, "R3");  drive(20, 9, 1, "R3");
        drive(20, 8, 1, "R3");  drive(41, 10, 1, "R3");
        drive(16, 7, 1, "R6");  drive(30, 12, 1, "R6");
        drive(1, 1, 1, "R9");

        // R4 / R9: enables dropped one at a time
        ctrl[2] = 1'b0;
        drive(12, 6, 1, "R4"); drive(16, 7, 1, "R4"); drive(1, 1, 1, "R9");
        ctrl[1] = 1'b0;
        drive(16, 7, 1, "R4"); drive(1, 1, 1, "R9");
        ctrl[0] = 1'b0;
        drive(16, 7, 1, "R9"); drive(1, 1, 1, "R9");
        ctrl[2] = 1'b1;
        drive(12, 6, 1, "R4"); drive(16, 7, 1, "R4"); drive(25, 10, 1, "R4");
        ctrl[2:0] = 3'b111;

        // R5: all-zero corner words mean an empty window
        win_tl[0] = '0; win_br[0] = '0;
        drive(0, 0, 1, "R5"); drive(12, 6, 1, "R5");
        win_tl[1] = '0; win_br[1] = '0;
        win_tl[2] = '0; win_br[2] = '0;
        drive(0, 0, 1, "R5"); drive(16, 7, 1, "R5");
        win_br[2] = corner(3, 3);
        drive(0, 0, 1, "R3");
        win_tl[0] = corner(10, 5);  win_br[0] = corner(20, 8);
        win_tl[1] = corner(15, 6);  win_br[1] = corner(30, 12);
        win_tl[2] = corner(2, 2);   win_br[2] = corner(40, 20);

        // R7 / R10: global alpha sweep, per-pixel alpha input ignored
        for (int k = 0; k < 8; k++) begin
            int av [8] = '{0, 1, 37, 128, 200, 254, 255, 90};
            ctrl[31:24] = 8'(av[k]);
            ch1_alpha = 8'(k * 31);
            drive(12, 6, 1, (av[k] == 0 || av[k] == 255) ? "R10" : "R7");
            drive(16, 7, 1, "R7");
            drive(1, 1, 1, "R7");
        end

        // R8: per-pixel alpha selected, global value ignored
        ctrl[10] = 1'b1;
        for (int k = 0; k < 6; k++) begin
            int pv [6] = '{0, 255, 64, 129, 250, 17};
            ch1_alpha = 8'(pv[k]);
            ctrl[31:24] = 8'(255 - k * 40);
            drive(12, 6, 1, (pv[k] == 0 || pv[k] == 255) ? "R10" : "R8");
            drive(18, 8, 1, "R8");
        end
        ctrl[10] = 1'b0;
        ctrl[31:24] = 8'd255;
        ch_pix[0] = colour(1023, 0, 512);
        drive(12, 6, 1, "R10");

        // drain
        drive(0, 0, 0, "R2");
        drive(0, 0, 0, "R2");
        drive(0, 0, 0, "R2");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule